// File: doc/BRIEF.md
# Passive Serial Bitstream Loader

This block configures an attached FPGA over a passive serial link. After a start pulse it pulls the target's configuration-reset pin low, checks that the target acknowledges by pulling its status pin low, and releases the reset. It then waits for the status pin to rise, with a timeout. Bitstream bytes arrive on a valid/ready stream, and the block shifts each one out on a data pin against a generated serial clock.

After the byte flagged as last, the block checks the target's completion pin. When that pin is high, the block gives twelve trailing clock pulses and reports success. Every failure releases the pins and reports a code. All results hold until the next start pulse.

The FSM states are IDLE, HOLD (reset driven low), SETTLE (reset released, fixed wait), POLL (waiting for status to rise), FETCH (between bytes, stream ready), BIT_LO and BIT_HI (the two clock phases of one bit), CHK_DONE (completion sample), TRL_LO and TRL_HI (trailing pulses). The transitions are:

- IDLE→HOLD on start.
- HOLD→SETTLE when the hold expires with status low.
- HOLD→IDLE (code 1) when the hold expires with status high.
- SETTLE→POLL when the settle wait expires.
- POLL→FETCH when status reads high.
- POLL→IDLE (code 2) when the timeout expires.
- FETCH→BIT_LO on a stream handshake.
- FETCH→IDLE (code 4) on abort.
- BIT_LO→BIT_HI after a half-period.
- BIT_HI→BIT_LO for the next bit, BIT_HI→FETCH after bit 7 of a byte that is not last, and BIT_HI→CHK_DONE after bit 7 of the last byte.
- CHK_DONE→TRL_LO when the completion pin is high.
- CHK_DONE→IDLE (code 3) when the completion pin is low.
- TRL_LO→TRL_HI after a half-period.
- TRL_HI→TRL_LO while trailing pulses remain.
- TRL_HI→IDLE (success) after the twelfth pulse.

Top module: `ps_cfg_master`

## Requirements
- R1: A start pulse sampled in IDLE raises `busy` and drives `tgt_rst_n` low for exactly HOLD_US*CLK_MHZ clock cycles, beginning on the cycle after the start.
- R2: If `tgt_stat_n` is high on the last hold cycle, the block returns to IDLE with `err_code`=1, `tgt_rst_n` high and no clock pulses.
- R3: After the hold, the reset is released for SETTLE_US*CLK_MHZ cycles. If `tgt_stat_n` then stays low for TIMEOUT_MS*1000*CLK_MHZ cycles of polling, the block ends with `err_code`=2.
- R4: `s_ready` is high only between bytes, while the serial clock is low. Each handshake accepts exactly one byte, after which `s_ready` drops.
- R5: Each byte is sent least significant bit first. For every bit, `tgt_clk` is low for HALF_CYC cycles with the bit on `tgt_din`, then high for HALF_CYC cycles, and `tgt_din` does not change while `tgt_clk` is high.
- R6: If `tgt_cfg_ok` is low after the last bit of the byte flagged `s_last`, the block ends with `err_code`=3 and gives no trailing pulses.
- R7: If `tgt_cfg_ok` is high at that point, exactly 12 further `tgt_clk` pulses follow. The block then ends with `done_ok`=1 and `err_code`=0.
- R8: `abort` is honoured only in FETCH. It ends the run with `err_code`=4, `tgt_clk` low and `tgt_rst_n` high; a byte already being shifted is completed first.
- R9: `done_ok` and `err_code` hold after the run until the next start in IDLE, which clears them. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (sampled in IDLE) |
| abort | input | 1 | Stop the run between bytes |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final bitstream byte |
| s_ready | output | 1 | Block accepts a byte this cycle |
| tgt_rst_n | output | 1 | Target configuration reset, active low |
| tgt_clk | output | 1 | Serial configuration clock |
| tgt_din | output | 1 | Serial configuration data |
| tgt_stat_n | input | 1 | Target status, low while in reset |
| tgt_cfg_ok | input | 1 | Target completion indication |
| busy | output | 1 | A run is in progress |
| done_ok | output | 1 | Last run succeeded |
| err_code | output | 3 | 0 none, 1 status not asserted, 2 status timeout, 3 completion low, 4 aborted |

## Verification
A scoreboard compares every bit at each rising `tgt_clk` with the byte values pushed at each handshake. A design that sent MSB first, or that slipped a bit between bytes, would show mismatches there. The bench measures the reset-low length, each high phase and the number of trailing pulses, so an off-by-one hold counter or an 11- or 13-pulse tail is caught. Each failure path (status stuck high, status stuck low, completion low, abort between bytes) is driven to check that the right code is reported and the pins are released. A start pulse during a load checks that a design restarting mid-run would corrupt the bitstream.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SETTLE,
        ST_POLL,
        ST_FETCH,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_CHK_DONE,
        ST_TRL_LO,
        ST_TRL_HI
    } cfg_state_e;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_NO_STATUS = 3'd1,
        ERR_TIMEOUT   = 3'd2,
        ERR_NOT_DONE  = 3'd3,
        ERR_ABORT     = 3'd4
    } cfg_err_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cfg_delay_timer.sv
module cfg_delay_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R3: an expired count stays expired until reloaded (no wrap)
    a_r3_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         bit_out,
    output logic         last_bit
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh;
    logic [CW-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            idx <= '0;
        end else if (load) begin
            sh  <= din;
            idx <= '0;
        end else if (shift) begin
            sh  <= sh >> 1;
            idx <= idx + 1'b1;
        end
    end

    assign bit_out  = sh[0];
    assign last_bit = (idx == CW'(W - 1));

    // R5: a shift never happens past the final bit of a byte
    a_r5_no_overshift: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last_bit);

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
    import cfg_pkg::*;
#(
    parameter int CLK_MHZ    = 50,
    parameter int HOLD_US    = 2,
    parameter int SETTLE_US  = 2,
    parameter int TIMEOUT_MS = 100,
    parameter int HALF_CYC   = 4,
    parameter int TRAIL_PULSES = 12,
    parameter int BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              tgt_rst_n,
    output logic              tgt_clk,
    output logic              tgt_din,
    input  logic              tgt_stat_n,
    input  logic              tgt_cfg_ok,
    output logic              busy,
    output logic              done_ok,
    output logic [2:0]        err_code
);
    localparam int HOLD_CYC = HOLD_US * CLK_MHZ;
    localparam int SETL_CYC = SETTLE_US * CLK_MHZ;
    localparam int TO_CYC   = TIMEOUT_MS * 1000 * CLK_MHZ;
    localparam int MAX_CYC  = max3(HOLD_CYC, SETL_CYC, max3(TO_CYC, HALF_CYC, 1));
    localparam int TW       = $clog2(MAX_CYC + 1);
    localparam int PW       = $clog2(TRAIL_PULSES + 1);

    cfg_state_e state, nstate;

    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          sh_load, sh_shift, sh_bit, sh_lastbit;
    logic          byte_last;
    logic [PW-1:0] trl_cnt;
    logic          trl_clr, trl_inc;
    logic          res_set, res_clr, res_ok;
    cfg_err_e      res_err;

    cfg_delay_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    cfg_bit_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .din      (s_data),
        .shift    (sh_shift),
        .bit_out  (sh_bit),
        .last_bit (sh_lastbit)
    );

    // next-state and control
    always_comb begin
        nstate   = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        trl_clr  = 1'b0;
        trl_inc  = 1'b0;
        res_set  = 1'b0;
        res_clr  = 1'b0;
        res_ok   = 1'b0;
        res_err  = ERR_NONE;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nstate   = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOLD_CYC - 1);
                    res_clr  = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    if (tgt_stat_n) begin
                        nstate  = ST_IDLE;
                        res_set = 1'b1;
                        res_err = ERR_NO_STATUS;
                    end else begin
                        nstate   = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(SETL_CYC - 1);
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    nstate   = ST_POLL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TO_CYC - 1);
                end
            end
            ST_POLL: begin
                if (tgt_stat_n) begin
                    nstate = ST_FETCH;
                end else if (tmr_zero) begin
                    nstate  = ST_IDLE;
                    res_set = 1'b1;
                    res_err = ERR_TIMEOUT;
                end
            end
            ST_FETCH: begin
                if (abort) begin
                    nstate  = ST_IDLE;
                    res_set = 1'b1;
                    res_err = ERR_ABORT;
                end else if (s_valid) begin
                    nstate   = ST_BIT_LO;
                    sh_load  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HALF_CYC - 1);
                end
            end
            ST_BIT_LO: begin
                if (tmr_zero) begin
                    nstate   = ST_BIT_HI;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HALF_CYC - 1);
                end
            end
            ST_BIT_HI: begin
                if (tmr_zero) begin
                    if (!sh_lastbit) begin
                        nstate   = ST_BIT_LO;
                        sh_shift = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(HALF_CYC - 1);
                    end else if (byte_last) begin
                        nstate = ST_CHK_DONE;
                    end else begin
                        nstate = ST_FETCH;
                    end
                end
            end
            ST_CHK_DONE: begin
                if (tgt_cfg_ok) begin
                    nstate   = ST_TRL_LO;
                    trl_clr  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HALF_CYC - 1);
                end else begin
                    nstate  = ST_IDLE;
                    res_set = 1'b1;
                    res_err = ERR_NOT_DONE;
                end
            end
            ST_TRL_LO: begin
                if (tmr_zero) begin
                    nstate   = ST_TRL_HI;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HALF_CYC - 1);
                end
            end
            ST_TRL_HI: begin
                if (tmr_zero) begin
                    if (trl_cnt == PW'(TRAIL_PULSES - 1)) begin
                        nstate  = ST_IDLE;
                        res_set = 1'b1;
                        res_ok  = 1'b1;
                    end else begin
                        nstate   = ST_TRL_LO;
                        trl_inc  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(HALF_CYC - 1);
                    end
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // state register and run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            byte_last <= 1'b0;
            trl_cnt   <= '0;
            done_ok   <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            state <= nstate;
            if (sh_load) byte_last <= s_last;
            if (trl_clr)      trl_cnt <= '0;
            else if (trl_inc) trl_cnt <= trl_cnt + 1'b1;
            if (res_clr) begin
                done_ok  <= 1'b0;
                err_code <= ERR_NONE;
            end else if (res_set) begin
                done_ok  <= res_ok;
                err_code <= res_err;
            end
        end
    end

    // Moore outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        tgt_rst_n = (state != ST_HOLD);
        tgt_clk   = (state == ST_BIT_HI) || (state == ST_TRL_HI);
        tgt_din   = ((state == ST_BIT_LO) || (state == ST_BIT_HI)) ? sh_bit : 1'b0;
        s_ready   = (state == ST_FETCH) && !abort;
    end

    // checker counters for phase lengths
    logic [31:0] lo_len, hi_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_len <= '0;
            hi_len <= '0;
        end else begin
            lo_len <= tgt_rst_n ? '0 : ((lo_len == '1) ? lo_len : lo_len + 1);
            hi_len <= !tgt_clk  ? '0 : ((hi_len == '1) ? hi_len : hi_len + 1);
        end
    end

    a_r1_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_rst_n) |-> (lo_len == 32'(HOLD_CYC)));

    a_r4_one_byte_per_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && s_valid) |=> !s_ready);

    a_r4_ready_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !tgt_clk);

    a_r5_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_clk && $past(tgt_clk)) |-> $stable(tgt_din));

    a_r5_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_clk) |-> (hi_len == 32'(HALF_CYC)));

    a_r7_ok_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |-> (err_code == ERR_NONE && !busy));

    a_r8_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && err_code == ERR_ABORT) |-> (!tgt_clk && tgt_rst_n));

    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(done_ok) && $stable(err_code)));

endmodule

// File: tb/tb_ps_cfg_master.sv
module tb_ps_cfg_master;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ   = 4;
    localparam int HOLD  = 2 * MHZ;
    localparam int HALF  = 2;
    localparam int TRAIL = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, abort = 1'b0;
    logic       s_valid = 1'b0, s_last = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_ready, t_rst_n, t_clk, t_din, t_stat_n;
    logic       t_cfg_ok = 1'b1;
    logic       busy, done_ok;
    logic [2:0] err_code;

    int  errors = 0, checks = 0;
    int  tgt_mode = 0;         // 0 normal, 1 status stuck high, 2 status stuck low
    logic [4:0] rst_hist = '1;

    logic exp_q[$];
    int  lo_len = 0, trail = 0, hi_bad = 0, rdy_bad = 0, hi_len = 0;
    logic prev_clk = 1'b0;
    bit  finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps_cfg_master #(.CLK_MHZ(MHZ), .HOLD_US(2), .SETTLE_US(2), .TIMEOUT_MS(1),
                    .HALF_CYC(HALF), .TRAIL_PULSES(TRAIL), .BYTE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .tgt_rst_n(t_rst_n), .tgt_clk(t_clk), .tgt_din(t_din),
        .tgt_stat_n(t_stat_n), .tgt_cfg_ok(t_cfg_ok),
        .busy(busy), .done_ok(done_ok), .err_code(err_code)
    );

    // target model: status follows reset with a 5-cycle lag
    always @(posedge clk) rst_hist <= {rst_hist[3:0], t_rst_n};
    always_comb t_stat_n = (tgt_mode == 0) ? rst_hist[4] : (tgt_mode == 1);

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // monitor: scoreboard pop on every rising serial clock
    always @(negedge clk) begin
        if (start && !busy) begin
            lo_len = 0; trail = 0; hi_bad = 0; rdy_bad = 0;
        end
        if (!t_rst_n) lo_len++;
        if (t_clk && !prev_clk) begin
            if (exp_q.size() > 0) begin
                logic b;
                b = exp_q.pop_front();
                chk(t_din == b, "R5 bit order", t_din, b);
            end else begin
                trail++;
            end
        end
        if (t_clk) hi_len++;
        else begin
            if (prev_clk && hi_len != HALF) hi_bad++;
            hi_len = 0;
        end
        if (s_ready && t_clk) rdy_bad++;
        prev_clk = t_clk;
    end

    task automatic start_run();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic last);
        @(negedge clk);
        s_valid = 1'b1; s_data = b; s_last = last;
        forever begin
            @(negedge clk);
            if (s_ready) break;
        end
        @(posedge clk);
        for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
        #1 s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!busy) return;
        end
        chk(0, "R9 run end", busy, 0);
    endtask

    task automatic load_ok(input string tag);
        wait_idle();
        chk(done_ok == 1'b1, tag, done_ok, 1);
        chk(err_code == 3'd0, tag, err_code, 0);
        chk(trail == TRAIL, "R7 trailing pulses", trail, TRAIL);
        chk(exp_q.size() == 0, "R5 all bits sent", exp_q.size(), 0);
        chk(hi_bad == 0, "R5 high phase length", hi_bad, 0);
        chk(rdy_bad == 0, "R4 ready while clock high", rdy_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk(busy == 0 && done_ok == 0 && err_code == 0, "R9 reset outputs", busy, 0);
        chk(t_rst_n == 1 && t_clk == 0 && s_ready == 0, "R1 reset pins", t_rst_n, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 + R5 + R7: three-byte load
        start_run();
        chk(busy == 1 && t_rst_n == 0, "R1 busy and reset low", busy, 1);
        send(8'hA5, 1'b0);
        chk(lo_len == HOLD, "R1 hold length", lo_len, HOLD);
        send(8'h3C, 1'b0);
        send(8'h01, 1'b1);
        load_ok("R7 success");

        // R9: result held, then cleared by new start; start while busy ignored
        repeat (20) @(negedge clk);
        chk(done_ok == 1 && err_code == 0, "R9 result held", done_ok, 1);
        start_run();
        chk(done_ok == 0, "R9 cleared by start", done_ok, 0);
        send(8'h80, 1'b0);
        start_run();
        send(8'hFF, 1'b1);
        load_ok("R9 start while busy ignored");

        // R2: status never asserted
        tgt_mode = 1;
        start_run();
        wait_idle();
        chk(err_code == 3'd1, "R2 status not asserted", err_code, 1);
        chk(trail == 0 && t_rst_n == 1, "R2 no clocks, reset released", trail, 0);
        chk(lo_len == HOLD, "R1 hold before status check", lo_len, HOLD);

        // R3: status never released
        tgt_mode = 2;
        start_run();
        wait_idle();
        chk(err_code == 3'd2, "R3 status timeout", err_code, 2);
        chk(done_ok == 0 && trail == 0, "R3 no success", done_ok, 0);
        tgt_mode = 0;

        // R6: completion low
        t_cfg_ok = 1'b0;
        start_run();
        send(8'h5A, 1'b1);
        wait_idle();
        chk(err_code == 3'd3, "R6 completion low", err_code, 3);
        chk(trail == 0, "R6 no trailing pulses", trail, 0);
        chk(exp_q.size() == 0, "R6 byte fully sent", exp_q.size(), 0);
        t_cfg_ok = 1'b1;

        // R8: abort between bytes
        start_run();
        send(8'hC3, 1'b0);
        @(negedge clk) abort = 1'b1;
        wait_idle();
        abort = 1'b0;
        chk(err_code == 3'd4, "R8 aborted code", err_code, 4);
        chk(t_clk == 0 && t_rst_n == 1, "R8 pins released", t_clk, 0);
        chk(exp_q.size() == 0 && trail == 0, "R8 current byte completed", exp_q.size(), 0);
        chk(s_ready == 0, "R4 no ready when idle", s_ready, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule